// File: doc/BRIEF.md
# Unsigned Carry-Save Tree Multiplier

This block takes two unsigned operands of `W` bits (32 by default) and returns their full `2W`-bit product (64 bits by default). Every pairing of an operand-A bit with an operand-B bit gives one AND-gate bit product, so the default width has 1024 of them. Each bit product is placed in the column equal to the sum of its two bit indices.

A tree of 3:2 counters (full adders) and 2:2 counters (half adders) then compresses the columns. No carry ripples inside a layer: a counter writes its sum into its own column and its carry into the next column up. Each layer reduces a column only far enough to meet that layer's height limit. The limits, taken from the top down, belong to the series 2, 3, 4, 6, 9, 13, 19, 28, and each limit is the one after it times 1.5, rounded down. A half adder appears only when a column's excess over its limit is odd.

A single `2W`-bit carry-propagate adder sums the two rows that remain. A register captures that sum one clock after a valid operand pair is sampled. The block is a one-cycle multiplier for datapaths that take the product from a flop, such as multiply-accumulate units.

Top module: `tree_mul`

## Requirements
- R1: While `rst` is high at a rising clock edge, `product` is cleared to 0 and `out_valid` to 0.
- R2: `out_valid` after each rising edge equals the value that `in_valid` had at that edge.
- R3: When `in_valid` is high at a rising edge, `product` after that edge equals the exact unsigned product `a*b`, zero-extended to `2W` bits.
- R4: When `in_valid` is low at a rising edge, `product` keeps its previous value whatever `a` and `b` are.
- R5: A zero operand on either side gives a product of 0.
- R6: Multiplying by 1 returns the other operand, zero-extended.
- R7: All-ones times all-ones gives `2^(2W) - 2^(W+1) + 1`, which is 0xFFFFFFFE00000001 for W=32. The adder's carry out of the top bit is dropped.
- R8: Powers of two on both operands give a single set bit at position i+j. This holds for every i and j, up to the top bit 2W-2.
- R9: The result is correct for every operand pair at a small width (exhaustive at W=5) and for random pairs at the default width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands on `a`/`b` are sampled this cycle |
| a | input | W | Multiplicand, unsigned |
| b | input | W | Multiplier, unsigned |
| out_valid | output | 1 | `product` was loaded at the last edge |
| product | output | 2W | Registered unsigned product |

## Verification
The bench aims at the column extremes: all-ones operands, single-bit operands across every bit position, identities and zeros. A tree that mishandled one column's limit, dropped a carry at a layer boundary or misplaced a half adder would give wrong product bits. Powers of two find any bit product routed to the wrong column. All-ones finds a bad top column or a misused final carry. A small width is swept exhaustively so that every column height pattern is covered. An idle cycle with changed operands shows whether the register loads without `in_valid`, and reset is checked for a stale product or valid.

// File: rtl/tree_mul.sv
module tree_mul #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         out_valid,
  output logic [2*W-1:0] product
);
  localparam int PW = 2 * W;

  function automatic int limit_at(int idx);
    int d;
    d = 2;
    for (int i = 0; i < 16; i++)
      if (i < idx) d = (d * 3) / 2;
    return d;
  endfunction

  function automatic int layer_count(int height);
    int n;
    n = 0;
    for (int i = 0; i < 16; i++)
      if (limit_at(i) < height) n = i + 1;
    return n;
  endfunction

  localparam int NL = layer_count(W);

  logic [W-1:0] col  [PW];
  logic [W-1:0] ncol [PW];
  int           hgt  [PW];
  int           nhgt [PW];
  logic [PW-1:0] row0, row1;

  always_comb begin
    int lim, excess, nfa, nha, k;
    for (int c = 0; c < PW; c++) begin
      col[c] = '0;
      hgt[c] = 0;
      ncol[c] = '0;
      nhgt[c] = 0;
    end
    for (int i = 0; i < W; i++)
      for (int j = 0; j < W; j++) begin
        col[i+j][hgt[i+j]] = a[i] & b[j];
        hgt[i+j] = hgt[i+j] + 1;
      end
    for (int s = NL - 1; s >= 0; s--) begin
      lim = limit_at(s);
      for (int c = 0; c < PW; c++) begin
        ncol[c] = '0;
        nhgt[c] = 0;
      end
      for (int c = 0; c < PW; c++) begin
        excess = hgt[c] + nhgt[c] - lim;
        nfa = (excess > 0) ? excess / 2 : 0;
        nha = (excess > 0) ? excess % 2 : 0;
        k = 0;
        for (int f = 0; f < W; f++)
          if (f < nfa) begin
            ncol[c][nhgt[c]] = col[c][k] ^ col[c][k+1] ^ col[c][k+2];
            nhgt[c] = nhgt[c] + 1;
            if (c + 1 < PW) begin
              ncol[c+1][nhgt[c+1]] = (col[c][k] & col[c][k+1]) |
                                     (col[c][k+2] & (col[c][k] ^ col[c][k+1]));
              nhgt[c+1] = nhgt[c+1] + 1;
            end
            k = k + 3;
          end
        if (nha > 0) begin
          ncol[c][nhgt[c]] = col[c][k] ^ col[c][k+1];
          nhgt[c] = nhgt[c] + 1;
          if (c + 1 < PW) begin
            ncol[c+1][nhgt[c+1]] = col[c][k] & col[c][k+1];
            nhgt[c+1] = nhgt[c+1] + 1;
          end
          k = k + 2;
        end
        for (int p = 0; p < W; p++)
          if (p >= k && p < hgt[c]) begin
            ncol[c][nhgt[c]] = col[c][p];
            nhgt[c] = nhgt[c] + 1;
          end
      end
      for (int c = 0; c < PW; c++) begin
        col[c] = ncol[c];
        hgt[c] = nhgt[c];
      end
    end
    for (int c = 0; c < PW; c++) begin
      row0[c] = (hgt[c] > 0) ? col[c][0] : 1'b0;
      row1[c] = (hgt[c] > 1) ? col[c][1] : 1'b0;
    end
  end

  wire [PW-1:0] total = row0 + row1;

  always_ff @(posedge clk) begin
    if (rst) begin
      product   <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) product <= total;
    end
  end

  wire [PW-1:0] a_wide = {{W{1'b0}}, a};
  wire [PW-1:0] b_wide = {{W{1'b0}}, b};

  AST_VALID_SET: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R2
  AST_VALID_CLR: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R2
  AST_EXACT_PRODUCT: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> product == $past(a_wide) * $past(b_wide)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(product)); // R4
  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (a == '0 || b == '0)) |=> product == '0); // R5
endmodule

// File: tb/sim_tree_mul.sv
module sim_tree_mul;
  localparam int W  = 32;
  localparam int SW = 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst, in_valid, out_valid;
  logic [W-1:0]  a, b;
  logic [2*W-1:0] product;
  logic          s_valid, s_out_valid;
  logic [SW-1:0] sa, sb;
  logic [2*SW-1:0] s_product;

  int errors = 0;
  int checks = 0;

  tree_mul #(.W(W)) u0 (.clk(clk), .rst(rst), .in_valid(in_valid), .a(a), .b(b),
                        .out_valid(out_valid), .product(product));
  tree_mul #(.W(SW)) u_small (.clk(clk), .rst(rst), .in_valid(s_valid), .a(sa), .b(sb),
                              .out_valid(s_out_valid), .product(s_product));

  task automatic check64(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic mul(string tag, logic [W-1:0] x, logic [W-1:0] y);
    @(negedge clk);
    a = x; b = y; in_valid = 1'b1;
    @(negedge clk);
    check64(tag, product, {32'd0, x} * {32'd0, y});
    check64({tag, " valid"}, {63'd0, out_valid}, 64'd1);
  endtask

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] held;
    rst = 1'b1; in_valid = 1'b0; a = '1; b = '1;
    s_valid = 1'b0; sa = '0; sb = '0;
    repeat (3) @(negedge clk);
    in_valid = 1'b1;
    @(negedge clk);
    check64("R1 product", product, 64'd0);
    check64("R1 valid", {63'd0, out_valid}, 64'd0);
    rst = 1'b0;

    mul("R7 ones", '1, '1);
    check64("R7 const", product, 64'hFFFFFFFE00000001);
    mul("R5 zero a", 32'd0, 32'hDEADBEEF);
    mul("R5 zero b", 32'hFFFFFFFF, 32'd0);
    mul("R6 one a", 32'd1, 32'h89ABCDEF);
    mul("R6 one b", 32'hFFFFFFFF, 32'd1);
    for (int i = 0; i < W; i++)
      for (int j = 0; j < W; j += 5)
        mul("R8 pow2", 32'd1 << i, 32'd1 << j);
    mul("R8 top", 32'h80000000, 32'h80000000);

    mul("R4 setup", 32'd12345, 32'd6789);
    held = product;
    @(negedge clk);
    in_valid = 1'b0; a = 32'hFFFF0000; b = 32'h0000FFFF;
    @(negedge clk);
    check64("R4 hold", product, held);
    check64("R2 idle valid", {63'd0, out_valid}, 64'd0);

    for (int n = 0; n < 10000; n++)
      mul("R9 random", $urandom, $urandom);

    for (int x = 0; x < (1 << SW); x++)
      for (int y = 0; y < (1 << SW); y++) begin
        @(negedge clk);
        sa = SW'(x); sb = SW'(y); s_valid = 1'b1;
        @(negedge clk);
        check64("R9 exhaustive", {54'd0, s_product}, 64'(x * y));
      end

    rst = 1'b1;
    @(negedge clk);
    check64("R1 late product", product, 64'd0);
    check64("R1 late valid", {63'd0, out_valid}, 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule